// File: doc/BRIEF.md
# Pipelined Address-Stage Bus Arbiter

This block chooses which of N masters may use the single address stage of a shared bus. The bus has separate read and write data stages. It accepts one transfer in advance: a second address in the same direction may be placed while the first transfer is still moving data. For each direction the arbiter keeps a pending count, shown as a virtual stage value: PRIM (nothing outstanding), SEC (one outstanding) and STALL (two outstanding, so no more addresses in that direction). It also keeps registers that name the primary and secondary masters owning each data stage.

A granted address is presented to the slave side until the slave answers or a timeout counter expires. The outcome is reported to masters as an acknowledge code. Data-phase beats are accepted only from the master that currently owns the matching data stage. The final beat hands the stage to the secondary master, if there is one. The arbiter can grant a new address in the cycle right after any address phase ends.

Top module: `pipe_addr_arb`

## Requirements
- R1: While rst_n is low and right after it is released: ab_busy, rd_busy and wr_busy are 0, a_gnt and ack_valid are 0, rd_vst and wr_vst are 0 (PRIM), and rd_pm, rd_sm, wr_pm and wr_sm are 255 (no master).
- R2: A request from master i (a_req[i], with direction a_rnw[i], 1 meaning read) is eligible only when the virtual stage of its direction is not 2 (STALL). A grant happens only at an edge where the address stage is idle. It shows as a one-hot a_gnt pulse lasting one cycle after that edge.
- R3: Among eligible requests, the winner has the largest a_prio field (bits i*PW upward for master i). Ties go to the lowest index.
- R4: A grant sets ab_busy and drives s_req, s_mid (the master index) and s_rnw. It raises the virtual stage of that direction by one step: 0 PRIM to 1 SEC, or 1 SEC to 2 STALL.
- R5: When s_ack is high while the address stage is busy, the phase ends at that edge. The owner goes into the primary register of its direction if that register is empty, and ack_code is 1. Otherwise it goes into the secondary register, and ack_code is 2. ack_valid pulses for one cycle with ack_mid set to the owner.
- R6: If TMO busy cycles pass without s_ack, the phase ends with ack_code 3. The virtual stage of that direction drops by one step, and no master register changes.
- R7: d_ack is high in the same cycle as d_valid only when d_mid is not 255 and equals the primary master of the direction given by d_rnw.
- R8: An acknowledged beat with d_last high moves the secondary master into the primary register. It sets the secondary register to 255 and lowers the virtual stage of that direction by one step.
- R9: After an address phase ends, a waiting eligible request is granted at the very next edge.
- R10: rd_busy and wr_busy are high exactly when the primary master register of that direction holds a master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | N | Address request per master |
| a_rnw | input | N | Direction per master, 1 = read |
| a_prio | input | N*PW | Priority field per master |
| a_gnt | output | N | One-hot grant pulse |
| s_req | output | 1 | Address phase presented to slave |
| s_rnw | output | 1 | Direction of the presented address |
| s_mid | output | 8 | Master owning the presented address |
| s_ack | input | 1 | Slave accepts the address |
| ack_valid | output | 1 | Address phase outcome pulse |
| ack_code | output | 2 | 1 primary, 2 secondary, 3 timeout |
| ack_mid | output | 8 | Master the outcome belongs to |
| d_valid | input | 1 | Data beat request |
| d_rnw | input | 1 | Data beat direction, 1 = read |
| d_mid | input | 8 | Master issuing the data beat |
| d_last | input | 1 | Final beat of the transfer |
| d_ack | output | 1 | Data beat accepted |
| rd_pm | output | 8 | Primary read master, 255 if none |
| rd_sm | output | 8 | Secondary read master, 255 if none |
| wr_pm | output | 8 | Primary write master, 255 if none |
| wr_sm | output | 8 | Secondary write master, 255 if none |
| ab_busy | output | 1 | Address stage busy |
| rd_busy | output | 1 | Read data stage busy |
| wr_busy | output | 1 | Write data stage busy |
| rd_vst | output | 2 | Read virtual stage: 0 PRIM, 1 SEC, 2 STALL |
| wr_vst | output | 2 | Write virtual stage: 0 PRIM, 1 SEC, 2 STALL |

## Verification
The assertions watch properties that must hold on every cycle. Grants are one-hot and coincide with a busy address stage. Outcome pulses carry a nonzero code and leave the stage idle. Accepted data beats always come from the current primary owner. A secondary master never exists without a primary, and virtual stages never take the unused encoding. The bench's scenarios are needed for the rest. Only they show that the right master wins a priority tie, that the timeout lands after exactly TMO cycles, that a read stall holds off reads while writes still go through, and that ownership moves correctly when a last beat and an address completion overlap.

// File: rtl/pipe_addr_arb.sv
module pipe_addr_arb #(
  parameter int N   = 4,
  parameter int PW  = 2,
  parameter int TMO = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  a_req,
  input  logic [N-1:0]  a_rnw,
  input  logic [N*PW-1:0] a_prio,
  output logic [N-1:0]  a_gnt,
  output logic          s_req,
  output logic          s_rnw,
  output logic [7:0]    s_mid,
  input  logic          s_ack,
  output logic          ack_valid,
  output logic [1:0]    ack_code,
  output logic [7:0]    ack_mid,
  input  logic          d_valid,
  input  logic          d_rnw,
  input  logic [7:0]    d_mid,
  input  logic          d_last,
  output logic          d_ack,
  output logic [7:0]    rd_pm,
  output logic [7:0]    rd_sm,
  output logic [7:0]    wr_pm,
  output logic [7:0]    wr_sm,
  output logic          ab_busy,
  output logic          rd_busy,
  output logic          wr_busy,
  output logic [1:0]    rd_vst,
  output logic [1:0]    wr_vst
);
  localparam int XW = (N > 1) ? $clog2(N) : 1;
  localparam logic [7:0] NONE = 8'hFF;
  localparam logic [1:0] STALL = 2'd2;

  logic [7:0]    pm [2];
  logic [7:0]    sm [2];
  logic [7:0]    pm_n [2];
  logic [7:0]    sm_n [2];
  logic [1:0]    vst [2];
  logic [1:0]    vst_n [2];
  logic [15:0]   cnt;
  logic [7:0]    cur_id;
  logic          cur_rnw;
  logic          win_ok;
  logic [XW-1:0] win;
  logic [PW-1:0] best;
  logic          gfire, done, tmo_hit, prim_slot;
  logic [1:0]    last;

  always_comb begin
    win_ok = 1'b0;
    win    = '0;
    best   = '0;
    for (int i = 0; i < N; i++)
      if (a_req[i] && vst[a_rnw[i]] != STALL &&
          (!win_ok || a_prio[i*PW +: PW] > best)) begin
        win_ok = 1'b1;
        win    = XW'(i);
        best   = a_prio[i*PW +: PW];
      end
  end

  assign gfire   = !ab_busy && win_ok;
  assign done    = ab_busy && s_ack;
  assign tmo_hit = ab_busy && !s_ack && cnt == 16'(TMO - 1);
  assign d_ack   = d_valid && d_mid != NONE && d_mid == pm[d_rnw];
  assign last[1] = d_ack && d_rnw && d_last;
  assign last[0] = d_ack && !d_rnw && d_last;
  assign prim_slot = (last[cur_rnw] ? sm[cur_rnw] : pm[cur_rnw]) == NONE;

  always_comb begin
    for (int d = 0; d < 2; d++) begin
      pm_n[d] = last[d] ? sm[d] : pm[d];
      sm_n[d] = last[d] ? NONE : sm[d];
      if (done && cur_rnw == 1'(d)) begin
        if (pm_n[d] == NONE) pm_n[d] = cur_id;
        else                 sm_n[d] = cur_id;
      end
      vst_n[d] = vst[d] + 2'(gfire && a_rnw[win] == 1'(d))
                        - 2'(last[d])
                        - 2'(tmo_hit && cur_rnw == 1'(d));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_busy   <= 1'b0;
      cnt       <= '0;
      cur_id    <= NONE;
      cur_rnw   <= 1'b0;
      a_gnt     <= '0;
      ack_valid <= 1'b0;
      ack_code  <= 2'd0;
      ack_mid   <= NONE;
      for (int d = 0; d < 2; d++) begin
        pm[d]  <= NONE;
        sm[d]  <= NONE;
        vst[d] <= 2'd0;
      end
    end else begin
      a_gnt     <= '0;
      ack_valid <= 1'b0;
      ack_code  <= 2'd0;
      for (int d = 0; d < 2; d++) begin
        pm[d]  <= pm_n[d];
        sm[d]  <= sm_n[d];
        vst[d] <= vst_n[d];
      end
      if (gfire) begin
        ab_busy <= 1'b1;
        cnt     <= '0;
        cur_id  <= 8'(win);
        cur_rnw <= a_rnw[win];
        a_gnt   <= N'(1) << win;
      end else if (done || tmo_hit) begin
        ab_busy   <= 1'b0;
        ack_valid <= 1'b1;
        ack_code  <= done ? (prim_slot ? 2'd1 : 2'd2) : 2'd3;
        ack_mid   <= cur_id;
      end else if (ab_busy) begin
        cnt <= cnt + 16'd1;
      end
    end
  end

  assign s_req   = ab_busy;
  assign s_mid   = cur_id;
  assign s_rnw   = cur_rnw;
  assign rd_pm   = pm[1];
  assign rd_sm   = sm[1];
  assign wr_pm   = pm[0];
  assign wr_sm   = sm[0];
  assign rd_vst  = vst[1];
  assign wr_vst  = vst[0];
  assign rd_busy = pm[1] != NONE;
  assign wr_busy = pm[0] != NONE;
endmodule

// File: rtl/pipe_addr_arb_chk.sv
module pipe_addr_arb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] a_gnt,
  input logic         ab_busy,
  input logic         ack_valid,
  input logic [1:0]   ack_code,
  input logic         d_ack,
  input logic         d_rnw,
  input logic [7:0]   d_mid,
  input logic [7:0]   rd_pm,
  input logic [7:0]   rd_sm,
  input logic [7:0]   wr_pm,
  input logic [7:0]   wr_sm,
  input logic [1:0]   rd_vst,
  input logic [1:0]   wr_vst
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(a_gnt)); // R2
  AST_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (|a_gnt) |-> ab_busy); // R4
  AST_VST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rd_vst != 2'd3 && wr_vst != 2'd3); // R4
  AST_ACK_CODE: assert property (@(posedge clk) disable iff (!rst_n) ack_valid |-> ack_code != 2'd0); // R5
  AST_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n) ack_valid |-> !ab_busy); // R9
  AST_DACK_OWNER: assert property (@(posedge clk) disable iff (!rst_n) d_ack |-> d_mid == (d_rnw ? rd_pm : wr_pm)); // R7
  AST_SEC_HAS_PRIM: assert property (@(posedge clk) disable iff (!rst_n) (rd_sm != 8'hFF |-> rd_pm != 8'hFF) and (wr_sm != 8'hFF |-> wr_pm != 8'hFF)); // R8
endmodule

bind pipe_addr_arb pipe_addr_arb_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_gnt(a_gnt), .ab_busy(ab_busy),
  .ack_valid(ack_valid), .ack_code(ack_code), .d_ack(d_ack),
  .d_rnw(d_rnw), .d_mid(d_mid), .rd_pm(rd_pm), .rd_sm(rd_sm),
  .wr_pm(wr_pm), .wr_sm(wr_sm), .rd_vst(rd_vst), .wr_vst(wr_vst)
);

// File: tb/pipe_addr_arb_bench.sv
`timescale 1ns/1ps
module pipe_addr_arb_bench;
  localparam int N = 4, PW = 2, TMO = 16;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] a_req = '0, a_rnw = '0, a_gnt;
  logic [N*PW-1:0] a_prio = '0;
  logic s_req, s_rnw, s_ack = 0, ack_valid, d_valid = 0, d_rnw = 0, d_last = 0, d_ack;
  logic [7:0] s_mid, ack_mid, d_mid = 8'hFF, rd_pm, rd_sm, wr_pm, wr_sm;
  logic [1:0] ack_code, rd_vst, wr_vst;
  logic ab_busy, rd_busy, wr_busy;

  int tests = 0, fails = 0;
  bit finished = 0;

  int m_busy, m_cnt, m_cur, m_rnw, m_gnt, m_ackv, m_ackc, m_ackm;
  int m_pm [2], m_sm [2], m_vst [2];

  always #5 clk = ~clk;

  pipe_addr_arb #(.N(N), .PW(PW), .TMO(TMO)) u_pipe_addr_arb (
    .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_rnw(a_rnw), .a_prio(a_prio),
    .a_gnt(a_gnt), .s_req(s_req), .s_rnw(s_rnw), .s_mid(s_mid), .s_ack(s_ack),
    .ack_valid(ack_valid), .ack_code(ack_code), .ack_mid(ack_mid),
    .d_valid(d_valid), .d_rnw(d_rnw), .d_mid(d_mid), .d_last(d_last), .d_ack(d_ack),
    .rd_pm(rd_pm), .rd_sm(rd_sm), .wr_pm(wr_pm), .wr_sm(wr_sm),
    .ab_busy(ab_busy), .rd_busy(rd_busy), .wr_busy(wr_busy),
    .rd_vst(rd_vst), .wr_vst(wr_vst)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pick();
    int w = -1, bp = -1;
    for (int i = 0; i < N; i++)
      if (a_req[i] && m_vst[a_rnw[i]] != 2 && int'(a_prio[i*PW +: PW]) > bp) begin
        w = i;
        bp = int'(a_prio[i*PW +: PW]);
      end
    return w;
  endfunction

  function automatic int exp_dack();
    return (d_valid && d_mid != 8'hFF && int'(d_mid) == m_pm[d_rnw]) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_busy = 0; m_cnt = 0; m_cur = 255; m_rnw = 0;
    m_gnt = 0; m_ackv = 0; m_ackc = 0; m_ackm = 255;
    for (int d = 0; d < 2; d++) begin m_pm[d] = 255; m_sm[d] = 255; m_vst[d] = 0; end
  endtask

  task automatic compare();
    chk("R2 R3 a_gnt", int'(a_gnt), m_gnt);
    chk("R4 ab_busy", int'(ab_busy), m_busy);
    chk("R4 s_req", int'(s_req), m_busy);
    if (m_busy) begin
      chk("R4 s_mid", int'(s_mid), m_cur);
      chk("R4 s_rnw", int'(s_rnw), m_rnw);
    end
    chk("R5 R6 ack_valid", int'(ack_valid), m_ackv);
    if (m_ackv) begin
      chk("R5 R6 ack_code", int'(ack_code), m_ackc);
      chk("R5 ack_mid", int'(ack_mid), m_ackm);
    end
    chk("R7 d_ack", int'(d_ack), exp_dack());
    chk("R8 rd_pm", int'(rd_pm), m_pm[1]);
    chk("R8 rd_sm", int'(rd_sm), m_sm[1]);
    chk("R8 wr_pm", int'(wr_pm), m_pm[0]);
    chk("R8 wr_sm", int'(wr_sm), m_sm[0]);
    chk("R4 R8 rd_vst", int'(rd_vst), m_vst[1]);
    chk("R4 R8 wr_vst", int'(wr_vst), m_vst[0]);
    chk("R10 rd_busy", int'(rd_busy), m_pm[1] != 255);
    chk("R10 wr_busy", int'(wr_busy), m_pm[0] != 255);
  endtask

  task automatic step();
    int w, r, np [2], ns [2];
    bit dn, tm, da;
    #1;
    compare();
    w  = pick();
    dn = m_busy && s_ack;
    tm = m_busy && !s_ack && m_cnt == TMO - 1;
    da = exp_dack() != 0;
    r  = int'(d_rnw);
    for (int d = 0; d < 2; d++) begin np[d] = m_pm[d]; ns[d] = m_sm[d]; end
    if (da && d_last) begin np[r] = m_sm[r]; ns[r] = 255; m_vst[r]--; end
    m_gnt = 0; m_ackv = 0; m_ackc = 0;
    if (dn) begin
      if (np[m_rnw] == 255) begin np[m_rnw] = m_cur; m_ackc = 1; end
      else begin ns[m_rnw] = m_cur; m_ackc = 2; end
      m_ackv = 1; m_ackm = m_cur; m_busy = 0;
    end else if (tm) begin
      m_ackv = 1; m_ackc = 3; m_ackm = m_cur; m_busy = 0; m_vst[m_rnw]--;
    end else if (!m_busy && w >= 0) begin
      m_busy = 1; m_cnt = 0; m_cur = w; m_rnw = int'(a_rnw[w]);
      m_vst[m_rnw]++; m_gnt = 1 << w;
    end else if (m_busy) m_cnt++;
    for (int d = 0; d < 2; d++) begin m_pm[d] = np[d]; m_sm[d] = ns[d]; end
    @(negedge clk);
  endtask

  initial begin
    int seen3;
    bit ack_en;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ab_busy", int'(ab_busy), 0);
    chk("R1 a_gnt", int'(a_gnt), 0);
    chk("R1 ack_valid", int'(ack_valid), 0);
    chk("R1 rd_vst", int'(rd_vst), 0);
    chk("R1 wr_vst", int'(wr_vst), 0);
    chk("R1 rd_pm", int'(rd_pm), 255);
    chk("R1 rd_sm", int'(rd_sm), 255);
    chk("R1 wr_pm", int'(wr_pm), 255);
    chk("R1 wr_sm", int'(wr_sm), 255);
    chk("R1 busy flags", int'({rd_busy, wr_busy}), 0);
    @(negedge clk);
    rst_n = 1;

    a_req = 4'b0110; a_rnw = 4'b1111; a_prio = 8'b01_01_01_01;
    step();
    chk("R3 tie lowest index", int'(a_gnt), 2);
    a_req = '0; s_ack = 1;
    step();
    chk("R5 primary code", int'(ack_code), 1);
    s_ack = 0;

    a_req = 4'b1111; a_rnw = 4'b0000; a_prio = 8'b01_11_01_01;
    step();
    chk("R3 highest priority", int'(a_gnt), 4);
    a_req = '0;
    seen3 = 0;
    for (int k = 0; k < TMO + 2; k++) begin
      step();
      if (ack_valid && ack_code == 2'd3) seen3 = 1;
    end
    chk("R6 timeout code seen", seen3, 1);
    chk("R6 write stage restored", int'(wr_vst), 0);

    a_req = 4'b0001; a_rnw = 4'b0001;
    step();
    s_ack = 1;
    step();
    chk("R5 secondary code", int'(ack_code), 2);
    s_ack = 0;
    step();
    chk("R2 no grant while read stalled", int'(a_gnt), 0);
    chk("R4 read stage stalled", int'(rd_vst), 2);
    a_rnw = 4'b0000;
    step();
    chk("R2 write granted during read stall", int'(a_gnt), 1);
    s_ack = 1;
    step();
    s_ack = 0;
    chk("R9 completion pulse", int'(ack_valid), 1);
    step();
    chk("R9 grant right after completion", int'(a_gnt), 1);
    a_req = '0;
    s_ack = 1;
    step();
    s_ack = 0;

    d_valid = 1; d_rnw = 1; d_mid = 8'd2; d_last = 1;
    #1;
    chk("R7 non-owner beat refused", int'(d_ack), 0);
    step();
    d_mid = 8'd1;
    step();
    chk("R8 secondary promoted", int'(rd_pm), 0);
    chk("R8 secondary cleared", int'(rd_sm), 255);
    chk("R8 read stage lowered", int'(rd_vst), 1);
    d_valid = 0;
    step();

    ack_en = 1;
    for (int c = 0; c < 3000; c++) begin
      if (c % 400 == 0) ack_en = ($urandom % 3) != 0;
      a_req  = N'($urandom);
      a_rnw  = N'($urandom);
      a_prio = (N*PW)'($urandom);
      s_ack  = ack_en && ($urandom % 4 == 0);
      d_valid = $urandom % 2;
      d_rnw   = $urandom % 2;
      d_last  = ($urandom % 3 == 0);
      case ($urandom % 4)
        0: d_mid = ($urandom % 2) ? 8'hFF : 8'($urandom % N);
        default: d_mid = 8'(m_pm[d_rnw]);
      endcase
      step();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog R1-scope run hung: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule